// File: doc/BRIEF.md
# CSR Read-Modify-Write Unit

This block carries out the six Zicsr instructions against a small bank of 32-bit control and status registers. Each cycle it takes one decoded instruction: the opcode, funct3, the rs1 and rd index fields, the value of the rs1 register and a 12-bit CSR address. In the same cycle it returns the value the destination register should receive, together with a write enable for that register. It also presents the new CSR value and a CSR write enable. The addressed CSR takes the new value on the next rising clock edge.

The operation is chosen by funct3. The swap forms replace the CSR with the operand. The set forms OR the operand into the CSR. The clear forms remove the operand's bits from the CSR. The operand is either the rs1 register value or the rs1 index field used as a zero-extended 5-bit immediate. Side effects are suppressed per instruction. A swap whose destination is x0 performs no read and no register write-back. A set or clear whose rs1 field is zero performs no CSR write.

The instruction input is qualified by `op_valid`. The unit has no back-pressure: it accepts one instruction in every cycle in which `op_valid` is high, so there is no ready signal. The result outputs carry no valid signal of their own; they are meaningful in the same cycle as the instruction.

Top module: `csr_rmw_unit`

## Requirements
- R1: After reset, all eight CSRs read as zero.
- R2: When `op_valid` is low, or the opcode is not 7'b1110011, `rd_we` and `csr_we` are 0 and no CSR changes.
- R3: When funct3 bit 2 is 1, the operand is `{27'b0, rs1_idx}`. When it is 0, the operand is `rs1_val`.
- R4: funct3 low bits 2'b01 select swap. `csr_we` is 1 and `csr_wdata` equals the operand, whatever the values of rd and rs1.
- R5: For swap, when `rd_idx` is zero, `rd_we` is 0 and `rd_rdata` is 0. When `rd_idx` is nonzero, `rd_we` is 1 and `rd_rdata` is the CSR value before the update.
- R6: funct3 low bits 2'b10 select set. The new value is old OR operand. `rd_we` is 1 and `rd_rdata` is the old value, even when `rd_idx` is zero.
- R7: funct3 low bits 2'b11 select clear. The new value is old AND NOT operand. `rd_we` is 1 and `rd_rdata` is the old value.
- R8: For set and clear, when `rs1_idx` is zero, `csr_we` is 0, `csr_wdata` is 0 and the CSR is unchanged, even if `rs1_val` is nonzero.
- R9: With the CSR opcode and funct3 of 3'b000 or 3'b100, `rd_we`, `csr_we`, `rd_rdata` and `csr_wdata` are all 0 and no CSR changes.
- R10: Only `csr_addr[2:0]` selects the register. Addresses that differ only in higher bits reach the same CSR.
- R11: All outputs depend only on the current inputs and the CSR state. A CSR write becomes visible to an instruction in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset, clears all CSRs |
| op_valid | input | 1 | Instruction on the inputs is valid this cycle |
| opcode | input | 7 | Instruction opcode |
| funct3 | input | 3 | Instruction funct3 field |
| rs1_idx | input | 5 | rs1 field, also the immediate |
| rd_idx | input | 5 | rd field |
| rs1_val | input | 32 | Value of register rs1 |
| csr_addr | input | 12 | CSR address |
| rd_we | output | 1 | Destination register write enable |
| rd_rdata | output | 32 | Old CSR value for the destination |
| csr_we | output | 1 | The CSR is written at the next edge |
| csr_wdata | output | 32 | New CSR value |

## Verification
A CSR entry that takes a wrong value stays hidden until an instruction addresses that register. It then shows up as a wrong `rd_rdata` in that same cycle, and as a wrong set or clear result derived from it. For this reason the bench re-reads registers straight after suppressed writes, using non-writing set instructions with rs1 equal to zero. A wrong suppression decision shows at `rd_we` or `csr_we` in the cycle of the instruction. A write that went through when it should not have shows one cycle later, on the next read of that CSR.

// File: rtl/csr_rmw_pkg.sv
package csr_rmw_pkg;

  localparam logic [6:0] SYSTEM_OPCODE = 7'b1110011;

  typedef enum logic [1:0] {
    CK_NONE  = 2'b00,
    CK_SWAP  = 2'b01,
    CK_SET   = 2'b10,
    CK_CLEAR = 2'b11
  } csr_kind_e;

endpackage

// File: rtl/csr_decode.sv
module csr_decode
  import csr_rmw_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [6:0]       opcode,
  input  logic [2:0]       funct3,
  input  logic [IDX_W-1:0] rs1_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output csr_kind_e        kind,
  output logic             use_imm,
  output logic             csr_read,
  output logic             csr_write
);

  logic is_csr;
  logic rd_zero;
  logic rs1_zero;

  assign is_csr   = op_valid && (opcode == SYSTEM_OPCODE);
  assign rd_zero  = (rd_idx == '0);
  assign rs1_zero = (rs1_idx == '0);
  assign use_imm  = funct3[2];

  always_comb begin
    kind      = CK_NONE;
    csr_read  = 1'b0;
    csr_write = 1'b0;
    if (is_csr) begin
      unique case (funct3[1:0])
        2'b01: begin
          kind      = CK_SWAP;
          csr_read  = !rd_zero;
          csr_write = 1'b1;
        end
        2'b10: begin
          kind      = CK_SET;
          csr_read  = 1'b1;
          csr_write = !rs1_zero;
        end
        2'b11: begin
          kind      = CK_CLEAR;
          csr_read  = 1'b1;
          csr_write = !rs1_zero;
        end
        default: begin
          kind      = CK_NONE;
          csr_read  = 1'b0;
          csr_write = 1'b0;
        end
      endcase
    end
  end

  // R2: nothing is enabled unless a valid CSR-opcode instruction is present
  p_quiet_when_not_csr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && opcode == SYSTEM_OPCODE) |-> (!csr_read && !csr_write));

  // R8: set or clear with a zero rs1 field never writes
  p_setclr_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (funct3[1] && rs1_idx == '0) |-> !csr_write);

  // R9: reserved funct3 values do nothing
  p_reserved_funct3_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (funct3[1:0] == 2'b00) |-> (!csr_read && !csr_write));

endmodule

// File: rtl/csr_alu.sv
module csr_alu
  import csr_rmw_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  csr_kind_e        kind,
  input  logic             use_imm,
  input  logic [IDX_W-1:0] rs1_idx,
  input  logic [XLEN-1:0]  rs1_val,
  input  logic [XLEN-1:0]  old_val,
  output logic [XLEN-1:0]  new_val
);

  localparam int PAD_W = XLEN - IDX_W;

  logic [XLEN-1:0] operand;

  assign operand = use_imm ? {{PAD_W{1'b0}}, rs1_idx} : rs1_val;

  always_comb begin
    unique case (kind)
      CK_SWAP:  new_val = operand;
      CK_SET:   new_val = old_val | operand;
      CK_CLEAR: new_val = old_val & ~operand;
      default:  new_val = old_val;
    endcase
  end

  // R6: set never drops a bit of the old value
  p_set_keeps_old_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CK_SET) |-> ((new_val & old_val) == old_val));

  // R7: clear never raises a bit that was not already set
  p_clear_no_new_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CK_CLEAR) |-> ((new_val & ~old_val) == '0));

  // R3: an immediate operand cannot reach the upper bits on swap
  p_imm_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CK_SWAP && use_imm) |-> (new_val[XLEN-1:IDX_W] == '0));

endmodule

// File: rtl/csr_file.sv
module csr_file #(
  parameter int XLEN     = 32,
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [XLEN-1:0]   rdata,
  input  logic              we,
  input  logic [XLEN-1:0]   wdata
);

  localparam int SEL_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [NUM_REGS-1:0][XLEN-1:0] regs;
  logic [SEL_W-1:0]              sel;

  assign sel   = addr[SEL_W-1:0];
  assign rdata = regs[sel];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs[g] <= '0;
      end else if (we && sel == SEL_W'(g)) begin
        regs[g] <= wdata;
      end
    end
  end

  // R11: a write lands in the selected entry at the next edge
  p_write_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (regs[$past(sel)] == $past(wdata)));

  // R8: without a write enable the whole array holds
  p_hold_without_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(regs));

  // R10: a write touches no more than one entry
  p_single_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ($countones(regs ^ $past(regs)) <= XLEN));

endmodule

// File: rtl/csr_rmw_unit.sv
module csr_rmw_unit
  import csr_rmw_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = 12,
  parameter int IDX_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [6:0]        opcode,
  input  logic [2:0]        funct3,
  input  logic [IDX_W-1:0]  rs1_idx,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [XLEN-1:0]   rs1_val,
  input  logic [ADDR_W-1:0] csr_addr,
  output logic              rd_we,
  output logic [XLEN-1:0]   rd_rdata,
  output logic              csr_we,
  output logic [XLEN-1:0]   csr_wdata
);

  csr_kind_e       kind;
  logic            use_imm;
  logic            do_read;
  logic            do_write;
  logic [XLEN-1:0] old_val;
  logic [XLEN-1:0] new_val;

  csr_decode #(.IDX_W(IDX_W)) u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .opcode    (opcode),
    .funct3    (funct3),
    .rs1_idx   (rs1_idx),
    .rd_idx    (rd_idx),
    .kind      (kind),
    .use_imm   (use_imm),
    .csr_read  (do_read),
    .csr_write (do_write)
  );

  csr_alu #(.XLEN(XLEN), .IDX_W(IDX_W)) u_alu (
    .clk     (clk),
    .rst_n   (rst_n),
    .kind    (kind),
    .use_imm (use_imm),
    .rs1_idx (rs1_idx),
    .rs1_val (rs1_val),
    .old_val (old_val),
    .new_val (new_val)
  );

  csr_file #(.XLEN(XLEN), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_file (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (csr_addr),
    .rdata (old_val),
    .we    (do_write),
    .wdata (new_val)
  );

  assign rd_we     = do_read;
  assign rd_rdata  = do_read ? old_val : '0;
  assign csr_we    = do_write;
  assign csr_wdata = do_write ? new_val : '0;

  // R5: a swap aimed at x0 produces no write-back
  p_swap_x0_no_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode == SYSTEM_OPCODE && funct3[1:0] == 2'b01 && rd_idx == '0)
      |-> (!rd_we && rd_rdata == '0));

  // R4: a valid swap always writes the CSR
  p_swap_always_writes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode == SYSTEM_OPCODE && funct3[1:0] == 2'b01) |-> csr_we);

  // R6: valid set or clear always hands the old value back
  p_setclr_reads_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode == SYSTEM_OPCODE && funct3[1]) |-> rd_we);

endmodule

// File: tb/csr_rmw_unit_bench.sv
module csr_rmw_unit_bench;

  localparam int XLEN = 32;
  localparam logic [6:0] SYS = 7'b1110011;

  typedef struct {
    logic        rdwe;
    logic [31:0] rdv;
    logic        we;
    logic [31:0] wd;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [6:0]  opcode = '0;
  logic [2:0]  funct3 = '0;
  logic [4:0]  rs1_idx = '0;
  logic [4:0]  rd_idx = '0;
  logic [31:0] rs1_val = '0;
  logic [11:0] csr_addr = '0;
  logic        rd_we;
  logic [31:0] rd_rdata;
  logic        csr_we;
  logic [31:0] csr_wdata;

  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 1'b0;
  exp_t sb[$];
  logic [31:0] model [8];
  logic [31:0] lfsr = 32'hACE1_2B57;
  event drv_ev;

  always #4 clk = ~clk;

  csr_rmw_unit u_csr_rmw_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .opcode    (opcode),
    .funct3    (funct3),
    .rs1_idx   (rs1_idx),
    .rd_idx    (rd_idx),
    .rs1_val   (rs1_val),
    .csr_addr  (csr_addr),
    .rd_we     (rd_we),
    .rd_rdata  (rd_rdata),
    .csr_we    (csr_we),
    .csr_wdata (csr_wdata)
  );

  function automatic logic [31:0] next_rand();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr;
  endfunction

  task automatic do_op(input logic v, input logic [6:0] opc, input logic [2:0] f3,
                       input logic [4:0] r1, input logic [4:0] rd,
                       input logic [31:0] r1v, input logic [11:0] a, input string tag);
    exp_t e;
    logic [31:0] opnd, old, nv;
    logic [2:0] ix;
    @(negedge clk);
    op_valid = v; opcode = opc; funct3 = f3; rs1_idx = r1; rd_idx = rd;
    rs1_val = r1v; csr_addr = a;
    ix   = a[2:0];
    old  = model[ix];
    opnd = f3[2] ? {27'b0, r1} : r1v;
    e.rdwe = 1'b0; e.rdv = '0; e.we = 1'b0; e.wd = '0; e.tag = tag;
    if (v && opc == SYS && f3[1:0] != 2'b00) begin
      if (f3[1:0] == 2'b01) begin
        e.rdwe = (rd != 0);
        e.rdv  = (rd != 0) ? old : '0;
        e.we   = 1'b1;
        e.wd   = opnd;
      end else begin
        nv     = (f3[1:0] == 2'b10) ? (old | opnd) : (old & ~opnd);
        e.rdwe = 1'b1;
        e.rdv  = old;
        e.we   = (r1 != 0);
        e.wd   = (r1 != 0) ? nv : '0;
      end
    end
    if (e.we) model[ix] = e.wd;
    sb.push_back(e);
    -> drv_ev;
  endtask

  // Read one CSR without side effects: set with rs1 field zero
  task automatic peek(input logic [11:0] a, input string tag);
    do_op(1'b1, SYS, 3'b010, 5'd0, 5'd9, 32'hFFFF_FFFF, a, tag);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(drv_ev);
      #1;
      e = sb.pop_front();
      n_tests++;
      if (rd_we !== e.rdwe || rd_rdata !== e.rdv || csr_we !== e.we || csr_wdata !== e.wd) begin
        n_fail++;
        $display("FAIL %s: got rd_we=%0b rd_rdata=%h csr_we=%0b csr_wdata=%h, expected %0b %h %0b %h",
                 e.tag, rd_we, rd_rdata, csr_we, csr_wdata, e.rdwe, e.rdv, e.we, e.wd);
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : driver
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 8; i++) peek(12'(i), "R1 reset value");

    do_op(1'b1, SYS, 3'b001, 5'd4, 5'd1, 32'hDEAD_BEEF, 12'h003, "R4 swap rd nonzero");
    do_op(1'b1, SYS, 3'b001, 5'd4, 5'd0, 32'h1234_5678, 12'h003, "R5 swap rd x0");
    peek(12'h003, "R11 value after swap");
    do_op(1'b1, SYS, 3'b010, 5'd7, 5'd2, 32'h0F00_000F, 12'h003, "R6 set reg");
    do_op(1'b1, SYS, 3'b110, 5'h15, 5'd0, 32'h0, 12'h003, "R6 R3 set imm rd x0");
    do_op(1'b1, SYS, 3'b011, 5'd6, 5'd2, 32'h1030_0007, 12'h003, "R7 clear reg");
    do_op(1'b1, SYS, 3'b111, 5'h1F, 5'd3, 32'hFFFF_FFFF, 12'h003, "R7 R3 clear imm");
    do_op(1'b1, SYS, 3'b010, 5'd0, 5'd2, 32'hFFFF_FFFF, 12'h003, "R8 set rs1 zero");
    do_op(1'b1, SYS, 3'b011, 5'd0, 5'd2, 32'hFFFF_FFFF, 12'h003, "R8 clear rs1 zero");
    do_op(1'b1, SYS, 3'b111, 5'd0, 5'd2, 32'hFFFF_FFFF, 12'h003, "R8 clear imm zero");
    peek(12'h003, "R8 unchanged");
    do_op(1'b1, SYS, 3'b000, 5'd5, 5'd5, 32'hFFFF_FFFF, 12'h003, "R9 funct3 000");
    do_op(1'b1, SYS, 3'b100, 5'd5, 5'd5, 32'hFFFF_FFFF, 12'h003, "R9 funct3 100");
    peek(12'h003, "R9 unchanged");
    do_op(1'b1, 7'b0110011, 3'b001, 5'd5, 5'd5, 32'hAAAA_5555, 12'h003, "R2 other opcode");
    do_op(1'b0, SYS, 3'b001, 5'd5, 5'd5, 32'hAAAA_5555, 12'h003, "R2 not valid");
    peek(12'h003, "R2 unchanged");
    do_op(1'b1, SYS, 3'b101, 5'h1B, 5'd0, 32'hFFFF_FFFF, 12'h805, "R3 R4 swap imm");
    peek(12'h005, "R10 alias read");
    do_op(1'b1, SYS, 3'b001, 5'd1, 5'd1, 32'h7777_0000, 12'hF80, "R10 alias write");
    peek(12'h000, "R10 alias read back");

    for (int pass = 0; pass < 6; pass++) begin
      for (int f = 0; f < 8; f++) begin
        for (int z = 0; z < 4; z++) begin
          logic [31:0] r;
          r = next_rand();
          do_op(1'b1, SYS, 3'(f), (z[0] ? 5'(r[4:0] | 5'd1) : 5'd0),
                (z[1] ? 5'(r[9:5] | 5'd1) : 5'd0), next_rand(), {r[20:12], r[2:0]},
                "R4 R5 R6 R7 R8 R9 sweep");
        end
      end
    end
    for (int i = 0; i < 8; i++) peek(12'(i), "R11 final contents");

    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule